// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of a parallel NOR flash bank. It waits for an internal program or erase operation to finish. After software has issued the command sequence, it starts the block with a poll address, the word it expects, and whether the operation was an erase. The block then reads the poll address again and again over a simple synchronous read port. Each time, it compares bit 7 of the returned word with the target value. While the operation is running, the flash returns the inverse of that bit.

A matching bit 7 does not by itself make the word valid, because the other data lines can settle after bit 7 does. So once bit 7 matches, the block issues one further confirming read. It returns that word as the result and raises a data-valid flag.

A cycle limit, loaded at start, bounds the wait. This covers cases such as an erase where every selected sector is protected: there the status stays busy for a bounded window and no success is reported. Either x16 or x8 width can be used.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, timeout_o, data_valid_o and rd_req_o are 0 and result_o is 0.
- R2: A start_i seen while busy_o is 0 is accepted. It latches the address, data, mode, width and limit, and busy_o is 1 from the next cycle. A start_i seen while busy_o is 1 has no effect.
- R3: rd_req_o stays high with a stable rd_addr_o (the latched address) until a cycle with rd_valid_i high. rd_data_i is sampled in that cycle and rd_req_o is low in the next cycle, so at most one read is ever outstanding.
- R4: The target for bit 7 of a status word is 1 for an erase (erase_i=1) and exp_data_i[7] for a program. Polling continues while bit 7 of the status word differs from the target.
- R5: Once a status word matches, exactly one more read is made. Its word, and not the matching status word, becomes result_o. done_o pulses for one cycle, and data_valid_o stays 1 until the next accepted start.
- R6: With x8_mode_i=1 at start, result_o[15:8] is 0 and result_o[7:0] is the low byte read. With x8_mode_i=0 the full 16-bit word is returned.
- R7: If no match has been seen once at least timeout_cycles_i busy cycles have elapsed, the block ends the poll. timeout_o pulses for one cycle, busy_o drops and data_valid_o stays 0. This happens within one further read of the limit.
- R8: done_o and timeout_o are never high together, and busy_o is 0 whenever either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | start a poll |
| addr_i | input | ADDR_W | poll address |
| exp_data_i | input | 16 | word written by the program operation |
| erase_i | input | 1 | 1: erase, target bit is 1 |
| x8_mode_i | input | 1 | 1: byte-wide bank |
| timeout_cycles_i | input | CNT_W | busy-cycle limit |
| rd_req_o | output | 1 | read request |
| rd_addr_o | output | ADDR_W | read address |
| rd_valid_i | input | 1 | read data strobe |
| rd_data_i | input | 16 | read data |
| busy_o | output | 1 | poll in progress |
| done_o | output | 1 | completion pulse |
| timeout_o | output | 1 | timeout pulse |
| data_valid_o | output | 1 | result_o holds confirmed data |
| result_o | output | 16 | confirmed word |

## Verification
The assertions check the read handshake on every cycle: the request is held with a stable address and drops after each strobe. They also check that busy rises on an accepted start, that done follows a completed read and lasts one cycle, and that the upper byte is zero in x8 mode. Finally they check that done and timeout never coincide and that a timeout never comes before the limit. Only the bench scenarios can show the rest: the erase target ignoring the data bit, the exact number of reads with the extra confirming read, the result being the confirming word rather than the status word, that a second start is ignored, and recovery after a timeout.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_STATUS, ST_CHECK, ST_CONFIRM_READ, ST_DONE, ST_TIMEOUT
  } poll_state_e;

  localparam int unsigned STATUS_BIT = 7;

  function automatic logic target_bit(input logic erase, input logic [7:0] lo);
    return erase ? 1'b1 : lo[STATUS_BIT];
  endfunction
endpackage

// File: rtl/flash_poll_rdport.sv
module flash_poll_rdport #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              beat_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;

  assign rd_req_o  = issue_i;
  assign rd_addr_o = addr_i;
  assign beat_o    = issue_i & rd_valid_i;
  assign data_o    = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (beat_o) data_q <= rd_data_i;
  end
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (run_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = (cnt_q >= lim_q);
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       exp_data_i,
  input  logic              erase_i,
  input  logic              x8_mode_i,
  input  logic [CNT_W-1:0]  timeout_cycles_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [15:0]       rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              data_valid_o,
  output logic [15:0]       result_o
);
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;

  poll_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              target_q, x8_q, valid_q;
  logic [DATA_W-1:0] result_q, status_w, masked_w;
  logic              accept, issue, beat, expired, match;

  assign busy_o = (state_q == ST_READ_STATUS) || (state_q == ST_CHECK) ||
                  (state_q == ST_CONFIRM_READ);
  assign accept = start_i && !busy_o;
  assign issue  = (state_q == ST_READ_STATUS) || (state_q == ST_CONFIRM_READ);

  flash_poll_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdport (
    .clk_i, .rst_ni,
    .issue_i   (issue),
    .addr_i    (addr_q),
    .rd_req_o,
    .rd_addr_o,
    .rd_valid_i,
    .rd_data_i,
    .beat_o    (beat),
    .data_o    (status_w)
  );

  flash_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .clear_i   (accept),
    .run_i     (busy_o),
    .limit_i   (timeout_cycles_i),
    .expired_o (expired)
  );

  assign match = (status_w[STATUS_BIT] == target_q);

  // byte mode returns only the low lane
  assign masked_w = x8_q ? {{(DATA_W-BYTE_W){1'b0}}, rd_data_i[BYTE_W-1:0]} : rd_data_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_TIMEOUT: state_d = accept ? ST_READ_STATUS : ST_IDLE;
      ST_READ_STATUS:  if (beat) state_d = ST_CHECK;
      ST_CHECK: begin
        if (match)        state_d = ST_CONFIRM_READ;
        else if (expired) state_d = ST_TIMEOUT;
        else              state_d = ST_READ_STATUS;
      end
      ST_CONFIRM_READ: if (beat) state_d = ST_DONE;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      target_q <= 1'b0;
      x8_q     <= 1'b0;
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q   <= addr_i;
        target_q <= target_bit(erase_i, exp_data_i[BYTE_W-1:0]);
        x8_q     <= x8_mode_i;
        valid_q  <= 1'b0;
      end else if (state_q == ST_CONFIRM_READ && beat) begin
        result_q <= masked_w;
        valid_q  <= 1'b1;
      end
    end
  end

  assign done_o       = (state_q == ST_DONE);
  assign timeout_o    = (state_q == ST_TIMEOUT);
  assign data_valid_o = valid_q;
  assign result_o     = result_q;
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  timeout_cycles_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              data_valid_o,
  input logic [15:0]       result_o,
  input logic              x8_q
);
  logic [CNT_W-1:0] busy_cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt_q <= '0;
      lim_q      <= '0;
    end else if (start_i && !busy_o) begin
      busy_cnt_q <= '0;
      lim_q      <= timeout_cycles_i;
    end else if (busy_o && busy_cnt_q != {CNT_W{1'b1}}) begin
      busy_cnt_q <= busy_cnt_q + 1'b1;
    end
  end

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  p_one_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_valid_i |=> !rd_req_o);
  p_busy_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  p_done_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rd_req_o && rd_valid_i));
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_x8_upper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o && x8_q |-> result_o[15:8] == 8'h00);
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  p_idle_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o || timeout_o |-> !busy_o);
  p_timeout_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> busy_cnt_q >= lim_q && !data_valid_o);
endmodule

bind flash_poll_ctrl flash_poll_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .timeout_cycles_i, .rd_req_o, .rd_addr_o,
  .rd_valid_i, .busy_o, .done_o, .timeout_o, .data_valid_o, .result_o,
  .x8_q (x8_q)
);

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, erase = 1'b0, x8 = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] exp_data = '0;
  logic [CNT_W-1:0] limit = '0;
  logic rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic rd_req, busy, done, tmo, dval;
  logic [ADDR_W-1:0] rd_addr;
  logic [15:0] result;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_flash_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .exp_data_i(exp_data), .erase_i(erase), .x8_mode_i(x8),
    .timeout_cycles_i(limit), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
    .timeout_o(tmo), .data_valid_o(dval), .result_o(result)
  );

  int checks = 0, errors = 0;
  int cyc = 0, start_cyc = 0, completions = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model
  int mem_lat = 0, mem_busy_n = 0, rd_cnt = 0, wait_cnt = 0;
  bit mem_never = 0, mem_target = 0;
  logic [15:0] mem_final = '0;
  logic [ADDR_W-1:0] mem_addr = '0;

  function automatic logic [15:0] pick(input int k);
    logic [15:0] w;
    if (mem_never || k < mem_busy_n) begin
      w = mem_final ^ 16'h3C15;
      w[7] = ~mem_target;
    end else if (k == mem_busy_n) begin
      w = ~mem_final;
      w[7] = mem_target;
    end else begin
      w = mem_final;
    end
    return w;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n && rd_req) begin
      if (wait_cnt >= mem_lat) begin
        check(rd_addr == mem_addr, "R3", "read address", int'(rd_addr), int'(mem_addr));
        rd_valid <= 1'b1;
        rd_data  <= pick(rd_cnt);
        rd_cnt++;
        wait_cnt = 0;
      end else begin
        rd_valid <= 1'b0;
        wait_cnt++;
      end
    end else begin
      rd_valid <= 1'b0;
      wait_cnt = 0;
    end
  end

  typedef struct {
    bit          is_timeout;
    logic [15:0] res;
    int          reads;
    int          lim;
    int          lat;
  } exp_t;
  exp_t sb[$];

  // monitor
  always @(negedge clk) begin
    if (rst_n && (done || tmo)) begin
      exp_t e;
      check(!(done && tmo), "R8", "done and timeout together", int'({done, tmo}), 2);
      check(!busy, "R8", "busy at end", int'(busy), 0);
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected completion", 1, 0);
      end else begin
        e = sb.pop_front();
        check(tmo == e.is_timeout, e.is_timeout ? "R7" : "R5", "end kind",
              int'(tmo), int'(e.is_timeout));
        if (e.is_timeout) begin
          check(dval == 1'b0, "R7", "data_valid on timeout", int'(dval), 0);
          check((cyc - start_cyc) >= e.lim && (cyc - start_cyc) <= e.lim + e.lat + 8,
                "R7", "timeout latency", cyc - start_cyc, e.lim);
        end else begin
          check(result == e.res, "R5", "result word", int'(result), int'(e.res));
          check(dval == 1'b1, "R5", "data_valid", int'(dval), 1);
          check(rd_cnt == e.reads, "R4", "read count", rd_cnt, e.reads);
        end
      end
      completions++;
    end
  end

  task automatic run_op(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                        input bit er, input bit b8, input int lat, input int n,
                        input int lim, input bit never, input logic [15:0] fin,
                        input bit poke);
    exp_t e;
    int prev;
    mem_lat = lat; mem_busy_n = n; mem_never = never; rd_cnt = 0;
    mem_target = er ? 1'b1 : d[7];
    mem_final = fin; mem_addr = a;
    e.is_timeout = never;
    e.res   = b8 ? {8'h00, fin[7:0]} : fin;
    e.reads = n + 2;
    e.lim   = lim;
    e.lat   = lat;
    sb.push_back(e);
    prev = completions;
    @(negedge clk);
    addr = a; exp_data = d; erase = er; x8 = b8; limit = CNT_W'(lim);
    start = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      addr = a ^ 24'h00FF00; erase = ~er; x8 = ~b8;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (completions == prev) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R5", "done one cycle", int'(done), 0);
    if (!never) check(dval == 1'b1, "R5", "data_valid held", int'(dval), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && tmo == 0, "R1", "status after reset",
          int'({busy, done, tmo}), 0);
    check(dval == 0 && rd_req == 0, "R1", "valid/req after reset", int'({dval, rd_req}), 0);
    check(result == 16'h0, "R1", "result after reset", int'(result), 0);
    rst_n = 1'b1;
    // program x16, several busy polls
    run_op(24'h001234, 16'hA5C3, 0, 0, 1, 3, 500, 0, 16'hA5C3, 0);
    // program with bit 7 zero, immediate match
    run_op(24'h00ABCD, 16'h1234, 0, 0, 0, 0, 500, 0, 16'h1234, 0);
    // erase: target 1 even though data bit 7 is 0 (R4)
    run_op(24'h3F0000, 16'h0000, 1, 0, 2, 4, 500, 0, 16'hFFFF, 0);
    // x8 mode (R6)
    run_op(24'h000042, 16'h009C, 0, 1, 1, 2, 500, 0, 16'hBE9C, 0);
    // x16 upper byte kept (R6)
    run_op(24'h000043, 16'h7E11, 0, 0, 0, 1, 500, 0, 16'h7E11, 0);
    // never completes -> timeout (R7)
    run_op(24'h100000, 16'h0080, 0, 0, 1, 0, 30, 1, 16'h0080, 0);
    // start during busy ignored (R2)
    run_op(24'h055555, 16'h00F0, 0, 0, 3, 5, 500, 0, 16'hC3F0, 1);
    check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
    // recovery after timeout, erase x8
    run_op(24'h200000, 16'h0000, 1, 1, 0, 2, 500, 0, 16'hFFFF, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule